// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Aspect Ratio

An 18 Kbit synchronous memory reached through two fully independent ports. Each port has its own clock, enable, write enable, synchronous set/reset, address, write bus and read bus. The storage is split into a 16 Kbit data array and a 2 Kbit parity array. Both ports see the same bits, each through the word shape its `*_WIDTH` parameter selects.

A port may be 1, 2, 4, 9, 18 or 36 bits wide. The three wide shapes carry one parity bit beside every data byte, on a bus of their own. The narrow shapes have no parity. Because the address mapping is linear in the data array, a wide write on one port can be read back piecewise through a narrow port on the other side, and the reverse.

Per-port parameters choose which clock edge is active and whether enable, write enable and set/reset are active-high or active-low. Two ports writing the same bits at the same moment leave those bits undefined; users keep such accesses apart.

Top module: `dpram_aspect`

## Requirements
- R1: Each port samples its inputs on its active clock edge and updates its read bus on that same edge. The clock-invert parameter set to 1 makes the falling edge active. The enable, write-enable and set/reset invert parameters set to 1 make those inputs active-low.
- R2: The width parameter values 36, 18, 9, 4, 2 and 1 give depths of 512, 1024, 2048, 4096, 8192 and 16384 words. The address bus is log2(depth) bits wide, so every address up to depth-1 is reachable.
- R3: A word at address A with data width D occupies bits A*D through A*D+D-1 of the 16384-bit data array. D is the width itself in the narrow modes and 32, 16 or 8 in the wide modes.
- R4: In the 36, 18 and 9 modes, the parity field is 4, 2 or 1 bits wide and occupies bits A*P through A*P+P-1 of the 2048-bit parity array, with P the parity width. Parity bit k accompanies data byte k.
- R5: In the 1, 2 and 4 modes, the parity read bus is always 0 and the parity write bus has no effect.
- R6: An enabled write stores the word and shows the written data and parity on the read bus after the same edge (write-first).
- R7: While enable is inactive, a port neither writes memory nor changes its read bus.
- R8: An enabled, active set/reset loads the read bus with the port's set/reset data and parity parameters. This takes priority over write-first, and a simultaneous write is still stored.
- R9: Asserting rst_ni low clears both read buses to 0 at once, without waiting for a clock. The memory contents are unchanged.
- R10: Data written through either port is read back through the other port at that port's own width and mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous active-low clear of both read registers |
| a_clk_i | input | 1 | Port A clock |
| a_en_i | input | 1 | Port A enable |
| a_we_i | input | 1 | Port A write enable |
| a_sr_i | input | 1 | Port A synchronous set/reset of the read register |
| a_addr_i | input | log2(16384/DA) | Port A word address |
| a_wdata_i | input | DA | Port A write data |
| a_wpar_i | input | max(1,A_WIDTH/9) | Port A write parity |
| a_rdata_o | output | DA | Port A read data |
| a_rpar_o | output | max(1,A_WIDTH/9) | Port A read parity |
| b_clk_i | input | 1 | Port B clock |
| b_en_i | input | 1 | Port B enable |
| b_we_i | input | 1 | Port B write enable |
| b_sr_i | input | 1 | Port B synchronous set/reset of the read register |
| b_addr_i | input | log2(16384/DB) | Port B word address |
| b_wdata_i | input | DB | Port B write data |
| b_wpar_i | input | max(1,B_WIDTH/9) | Port B write parity |
| b_rdata_o | output | DB | Port B read data |
| b_rpar_o | output | max(1,B_WIDTH/9) | Port B read parity |

DA and DB are the data widths: the width parameter in the narrow modes, and 8/9 of it in the wide modes.

## Verification
The hardest case to reach from the ports is a sub-word write landing inside a word that the other port wrote at a different width, followed by a read of the merged word. The read must show both the new byte or bit and the untouched neighbours, including the parity bits. To get there, the stimulus first fills the whole array through the 36-bit port. It then alternates randomly between a 36-bit port and an inverted-polarity 9-bit port, never enabling both at once, and a second instance pairs 4-bit and 1-bit ports. A bench-side model of the linear data and parity arrays predicts every read.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int DATA_BITS = 16384;
  localparam int PAR_BITS  = 2048;
  localparam int ROW_DW    = 32;
  localparam int ROW_PW    = ROW_DW / 8;
  localparam int ROW_W     = ROW_DW + ROW_PW;
  localparam int ROWS      = DATA_BITS / ROW_DW;
  localparam int ROW_AW    = $clog2(ROWS);

  typedef logic [ROWS-1:0][ROW_W-1:0] bank_t;

  function automatic bit has_par(input int w);
    return w >= 9;
  endfunction

  function automatic int data_w(input int w);
    return has_par(w) ? (w / 9) * 8 : w;
  endfunction

  function automatic int par_w(input int w);
    return has_par(w) ? w / 9 : 1;
  endfunction

  function automatic int addr_w(input int w);
    return $clog2(DATA_BITS / data_w(w));
  endfunction
endpackage

// File: rtl/dpram_lane.sv
module dpram_lane
  import dpram_pkg::*;
#(
  parameter int DW      = 32,
  parameter int PW      = 4,
  parameter bit HAS_PAR = 1'b1
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [5:0]       d_pos_i,
  input  logic [5:0]       p_pos_i,
  output logic [DW-1:0]    data_o,
  output logic [PW-1:0]    par_o
);
  assign data_o = row_i[d_pos_i +: DW];

  generate
    if (HAS_PAR) begin : g_par
      assign par_o = row_i[p_pos_i +: PW];
    end else begin : g_nopar
      logic unused_pos;
      assign unused_pos = ^p_pos_i;
      assign par_o      = '0;
    end
  endgenerate
endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int              WIDTH   = 36,
  parameter bit              CLK_INV = 1'b0,
  parameter bit              EN_INV  = 1'b0,
  parameter bit              WE_INV  = 1'b0,
  parameter bit              SR_INV  = 1'b0,
  parameter logic [ROW_DW-1:0] SR_DATA = '0,
  parameter logic [ROW_PW-1:0] SR_PAR  = '0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        we_i,
  input  logic                        sr_i,
  input  logic [addr_w(WIDTH)-1:0]    addr_i,
  input  logic [data_w(WIDTH)-1:0]    wdata_i,
  input  logic [par_w(WIDTH)-1:0]     wpar_i,
  input  bank_t                       peer_bank_i,
  output bank_t                       bank_o,
  output logic [data_w(WIDTH)-1:0]    rdata_o,
  output logic [par_w(WIDTH)-1:0]     rpar_o
);
  localparam int DW      = data_w(WIDTH);
  localparam int PW      = par_w(WIDTH);
  localparam bit HAS_PAR = has_par(WIDTH);
  localparam int AW      = addr_w(WIDTH);
  localparam int SW      = AW - ROW_AW;

  logic              clk_eff, en_act, we_act, sr_act;
  logic [31:0]       slot;
  logic [ROW_AW-1:0] row;
  logic [5:0]        d_pos, p_pos;
  logic [ROW_W-1:0]  own_row, peer_row;
  logic [DW-1:0]     peer_d, rd_d, rdata_q;
  logic [PW-1:0]     peer_p, rd_p, rpar_q;
  bank_t             bank_q;

  assign clk_eff = clk_i ^ CLK_INV;
  assign en_act  = en_i ^ EN_INV;
  assign we_act  = we_i ^ WE_INV;
  assign sr_act  = sr_i ^ SR_INV;

  // linear bit mapping: row holds 32 data + 4 parity bits
  assign slot  = 32'(addr_i) & ((32'd1 << SW) - 32'd1);
  assign row   = ROW_AW'(32'(addr_i) >> SW);
  assign d_pos = 6'(slot * DW);
  assign p_pos = HAS_PAR ? 6'(ROW_DW + slot * PW) : 6'(ROW_DW);

  assign own_row  = bank_q[row];
  assign peer_row = peer_bank_i[row];

  dpram_lane #(.DW(DW), .PW(PW), .HAS_PAR(HAS_PAR)) u_peer_lane (
    .row_i   (peer_row),
    .d_pos_i (d_pos),
    .p_pos_i (p_pos),
    .data_o  (peer_d),
    .par_o   (peer_p)
  );

  dpram_lane #(.DW(DW), .PW(PW), .HAS_PAR(HAS_PAR)) u_read_lane (
    .row_i   (own_row ^ peer_row),
    .d_pos_i (d_pos),
    .p_pos_i (p_pos),
    .data_o  (rd_d),
    .par_o   (rd_p)
  );

  // stored word = own bank XOR peer bank; each bank has one writer
  always_ff @(posedge clk_eff) begin
    if (en_act && we_act) begin
      bank_q[row][d_pos +: DW] <= wdata_i ^ peer_d;
      if (HAS_PAR) bank_q[row][p_pos +: PW] <= wpar_i ^ peer_p;
    end
  end

  always_ff @(posedge clk_eff or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rpar_q  <= '0;
    end else if (en_act) begin
      if (sr_act) begin
        rdata_q <= SR_DATA[DW-1:0];
        rpar_q  <= HAS_PAR ? SR_PAR[PW-1:0] : '0;
      end else if (we_act) begin
        rdata_q <= wdata_i;
        rpar_q  <= HAS_PAR ? wpar_i : '0;
      end else begin
        rdata_q <= rd_d;
        rpar_q  <= rd_p;
      end
    end
  end

  assign bank_o  = bank_q;
  assign rdata_o = rdata_q;
  assign rpar_o  = rpar_q;
endmodule

// File: rtl/dpram_aspect.sv
module dpram_aspect
  import dpram_pkg::*;
#(
  parameter int                A_WIDTH   = 36,
  parameter int                B_WIDTH   = 9,
  parameter bit                A_CLK_INV = 1'b0,
  parameter bit                A_EN_INV  = 1'b0,
  parameter bit                A_WE_INV  = 1'b0,
  parameter bit                A_SR_INV  = 1'b0,
  parameter bit                B_CLK_INV = 1'b0,
  parameter bit                B_EN_INV  = 1'b0,
  parameter bit                B_WE_INV  = 1'b0,
  parameter bit                B_SR_INV  = 1'b0,
  parameter logic [ROW_DW-1:0] A_SR_DATA = '0,
  parameter logic [ROW_PW-1:0] A_SR_PAR  = '0,
  parameter logic [ROW_DW-1:0] B_SR_DATA = '0,
  parameter logic [ROW_PW-1:0] B_SR_PAR  = '0
) (
  input  logic                          rst_ni,
  input  logic                          a_clk_i,
  input  logic                          a_en_i,
  input  logic                          a_we_i,
  input  logic                          a_sr_i,
  input  logic [addr_w(A_WIDTH)-1:0]    a_addr_i,
  input  logic [data_w(A_WIDTH)-1:0]    a_wdata_i,
  input  logic [par_w(A_WIDTH)-1:0]     a_wpar_i,
  output logic [data_w(A_WIDTH)-1:0]    a_rdata_o,
  output logic [par_w(A_WIDTH)-1:0]     a_rpar_o,
  input  logic                          b_clk_i,
  input  logic                          b_en_i,
  input  logic                          b_we_i,
  input  logic                          b_sr_i,
  input  logic [addr_w(B_WIDTH)-1:0]    b_addr_i,
  input  logic [data_w(B_WIDTH)-1:0]    b_wdata_i,
  input  logic [par_w(B_WIDTH)-1:0]     b_wpar_i,
  output logic [data_w(B_WIDTH)-1:0]    b_rdata_o,
  output logic [par_w(B_WIDTH)-1:0]     b_rpar_o
);
  bank_t bank_a, bank_b;

  dpram_port #(
    .WIDTH(A_WIDTH), .CLK_INV(A_CLK_INV), .EN_INV(A_EN_INV), .WE_INV(A_WE_INV),
    .SR_INV(A_SR_INV), .SR_DATA(A_SR_DATA), .SR_PAR(A_SR_PAR)
  ) u_port_a (
    .clk_i       (a_clk_i),
    .rst_ni      (rst_ni),
    .en_i        (a_en_i),
    .we_i        (a_we_i),
    .sr_i        (a_sr_i),
    .addr_i      (a_addr_i),
    .wdata_i     (a_wdata_i),
    .wpar_i      (a_wpar_i),
    .peer_bank_i (bank_b),
    .bank_o      (bank_a),
    .rdata_o     (a_rdata_o),
    .rpar_o      (a_rpar_o)
  );

  dpram_port #(
    .WIDTH(B_WIDTH), .CLK_INV(B_CLK_INV), .EN_INV(B_EN_INV), .WE_INV(B_WE_INV),
    .SR_INV(B_SR_INV), .SR_DATA(B_SR_DATA), .SR_PAR(B_SR_PAR)
  ) u_port_b (
    .clk_i       (b_clk_i),
    .rst_ni      (rst_ni),
    .en_i        (b_en_i),
    .we_i        (b_we_i),
    .sr_i        (b_sr_i),
    .addr_i      (b_addr_i),
    .wdata_i     (b_wdata_i),
    .wpar_i      (b_wpar_i),
    .peer_bank_i (bank_a),
    .bank_o      (bank_b),
    .rdata_o     (b_rdata_o),
    .rpar_o      (b_rpar_o)
  );
endmodule

// File: rtl/dpram_aspect_chk.sv
module dpram_aspect_chk
  import dpram_pkg::*;
#(
  parameter int                A_WIDTH   = 36,
  parameter int                B_WIDTH   = 9,
  parameter bit                A_CLK_INV = 1'b0,
  parameter bit                A_EN_INV  = 1'b0,
  parameter bit                A_WE_INV  = 1'b0,
  parameter bit                A_SR_INV  = 1'b0,
  parameter bit                B_CLK_INV = 1'b0,
  parameter bit                B_EN_INV  = 1'b0,
  parameter bit                B_WE_INV  = 1'b0,
  parameter bit                B_SR_INV  = 1'b0,
  parameter logic [ROW_DW-1:0] A_SR_DATA = '0,
  parameter logic [ROW_PW-1:0] A_SR_PAR  = '0,
  parameter logic [ROW_DW-1:0] B_SR_DATA = '0,
  parameter logic [ROW_PW-1:0] B_SR_PAR  = '0
) (
  input logic                          rst_ni,
  input logic                          a_clk_i,
  input logic                          a_en_i,
  input logic                          a_we_i,
  input logic                          a_sr_i,
  input logic [addr_w(A_WIDTH)-1:0]    a_addr_i,
  input logic [data_w(A_WIDTH)-1:0]    a_wdata_i,
  input logic [par_w(A_WIDTH)-1:0]     a_wpar_i,
  input logic [data_w(A_WIDTH)-1:0]    a_rdata_o,
  input logic [par_w(A_WIDTH)-1:0]     a_rpar_o,
  input logic                          b_clk_i,
  input logic                          b_en_i,
  input logic                          b_we_i,
  input logic                          b_sr_i,
  input logic [addr_w(B_WIDTH)-1:0]    b_addr_i,
  input logic [data_w(B_WIDTH)-1:0]    b_wdata_i,
  input logic [par_w(B_WIDTH)-1:0]     b_wpar_i,
  input logic [data_w(B_WIDTH)-1:0]    b_rdata_o,
  input logic [par_w(B_WIDTH)-1:0]     b_rpar_o
);
  localparam int A_DW = data_w(A_WIDTH);
  localparam int B_DW = data_w(B_WIDTH);

  logic a_clk, a_en, a_we, a_sr, b_clk, b_en, b_we, b_sr;
  assign a_clk = a_clk_i ^ A_CLK_INV;
  assign a_en  = a_en_i ^ A_EN_INV;
  assign a_we  = a_we_i ^ A_WE_INV;
  assign a_sr  = a_sr_i ^ A_SR_INV;
  assign b_clk = b_clk_i ^ B_CLK_INV;
  assign b_en  = b_en_i ^ B_EN_INV;
  assign b_we  = b_we_i ^ B_WE_INV;
  assign b_sr  = b_sr_i ^ B_SR_INV;

  AST_A_SR_LOAD: assert property (@(posedge a_clk) disable iff (!rst_ni)
    a_en && a_sr |=> a_rdata_o == A_SR_DATA[A_DW-1:0]); // R8
  AST_A_WRITE_FIRST: assert property (@(posedge a_clk) disable iff (!rst_ni)
    a_en && a_we && !a_sr |=> a_rdata_o == $past(a_wdata_i)); // R6
  AST_A_HOLD: assert property (@(posedge a_clk) disable iff (!rst_ni)
    !a_en |=> $stable(a_rdata_o) && $stable(a_rpar_o)); // R7
  AST_B_SR_LOAD: assert property (@(posedge b_clk) disable iff (!rst_ni)
    b_en && b_sr |=> b_rdata_o == B_SR_DATA[B_DW-1:0]); // R8
  AST_B_WRITE_FIRST: assert property (@(posedge b_clk) disable iff (!rst_ni)
    b_en && b_we && !b_sr |=> b_rdata_o == $past(b_wdata_i)); // R6
  AST_B_HOLD: assert property (@(posedge b_clk) disable iff (!rst_ni)
    !b_en |=> $stable(b_rdata_o) && $stable(b_rpar_o)); // R7
endmodule

bind dpram_aspect dpram_aspect_chk #(
  .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH),
  .A_CLK_INV(A_CLK_INV), .A_EN_INV(A_EN_INV), .A_WE_INV(A_WE_INV), .A_SR_INV(A_SR_INV),
  .B_CLK_INV(B_CLK_INV), .B_EN_INV(B_EN_INV), .B_WE_INV(B_WE_INV), .B_SR_INV(B_SR_INV),
  .A_SR_DATA(A_SR_DATA), .A_SR_PAR(A_SR_PAR), .B_SR_DATA(B_SR_DATA), .B_SR_PAR(B_SR_PAR)
) u_chk (.*);

// File: tb/dpram_aspect_bench.sv
module dpram_aspect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B_PERIOD   = CLK_PERIOD + 4;
  localparam logic [31:0] A_SRD = 32'hA5A5_0F0F;
  localparam logic [3:0]  A_SRP = 4'hC;
  localparam logic [31:0] B_SRD = 32'h0000_003C;
  localparam logic [3:0]  B_SRP = 4'h1;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_ni = 1'b0;

  // main DUT: A = 36-bit active-high rising; B = 9-bit, all inverted
  logic        a_en = 0, a_we = 0, a_sr = 0;
  logic [8:0]  a_addr = '0;
  logic [31:0] a_wdata = '0, a_rdata;
  logic [3:0]  a_wpar = '0, a_rpar;
  logic        b_en_n = 1, b_we_n = 1, b_sr_n = 1;
  logic [10:0] b_addr = '0;
  logic [7:0]  b_wdata = '0, b_rdata;
  logic        b_wpar = 0, b_rpar;

  dpram_aspect #(
    .A_WIDTH(36), .B_WIDTH(9),
    .B_CLK_INV(1'b1), .B_EN_INV(1'b1), .B_WE_INV(1'b1), .B_SR_INV(1'b1),
    .A_SR_DATA(A_SRD), .A_SR_PAR(A_SRP), .B_SR_DATA(B_SRD), .B_SR_PAR(B_SRP)
  ) u_dpram_aspect (
    .rst_ni(rst_ni),
    .a_clk_i(clk_a), .a_en_i(a_en), .a_we_i(a_we), .a_sr_i(a_sr), .a_addr_i(a_addr),
    .a_wdata_i(a_wdata), .a_wpar_i(a_wpar), .a_rdata_o(a_rdata), .a_rpar_o(a_rpar),
    .b_clk_i(clk_b), .b_en_i(b_en_n), .b_we_i(b_we_n), .b_sr_i(b_sr_n), .b_addr_i(b_addr),
    .b_wdata_i(b_wdata), .b_wpar_i(b_wpar), .b_rdata_o(b_rdata), .b_rpar_o(b_rpar)
  );

  // narrow DUT: A = 4-bit, B = 1-bit, default polarity
  logic        na_en = 0, na_we = 0;
  logic [11:0] na_addr = '0;
  logic [3:0]  na_wdata = '0, na_rdata;
  logic        na_wpar = 0, na_rpar;
  logic        nb_en = 0, nb_we = 0;
  logic [13:0] nb_addr = '0;
  logic [0:0]  nb_wdata = '0, nb_rdata;
  logic        nb_wpar = 0, nb_rpar;

  dpram_aspect #(.A_WIDTH(4), .B_WIDTH(1)) u_dpram_aspect_nar (
    .rst_ni(rst_ni),
    .a_clk_i(clk_a), .a_en_i(na_en), .a_we_i(na_we), .a_sr_i(1'b0), .a_addr_i(na_addr),
    .a_wdata_i(na_wdata), .a_wpar_i(na_wpar), .a_rdata_o(na_rdata), .a_rpar_o(na_rpar),
    .b_clk_i(clk_b), .b_en_i(nb_en), .b_we_i(nb_we), .b_sr_i(1'b0), .b_addr_i(nb_addr),
    .b_wdata_i(nb_wdata), .b_wpar_i(nb_wpar), .b_rdata_o(nb_rdata), .b_rpar_o(nb_rpar)
  );

  always #(CLK_PERIOD / 2) clk_a = ~clk_a;
  always #(B_PERIOD / 2) clk_b = ~clk_b;

  int n_chk = 0, n_err = 0;
  logic [16383:0] ref_d;
  logic [2047:0]  ref_p;
  logic [31:0] ea_d = '0;
  logic [3:0]  ea_p = '0;
  logic [7:0]  eb_d = '0;
  logic        eb_p = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op_a(input bit en, input bit we, input bit sr, input logic [8:0] ad,
                      input logic [31:0] d, input logic [3:0] p, input string tag);
    @(negedge clk_a);
    a_en = en; a_we = we; a_sr = sr; a_addr = ad; a_wdata = d; a_wpar = p;
    @(posedge clk_a); #1;
    if (en) begin
      if (we) begin
        ref_d[int'(ad)*32 +: 32] = d;
        ref_p[int'(ad)*4 +: 4]   = p;
      end
      if (sr) begin ea_d = A_SRD; ea_p = A_SRP; end
      else if (we) begin ea_d = d; ea_p = p; end
      else begin ea_d = ref_d[int'(ad)*32 +: 32]; ea_p = ref_p[int'(ad)*4 +: 4]; end
    end
    chk({tag, " A data"}, a_rdata, ea_d);
    chk({tag, " A parity"}, {28'd0, a_rpar}, {28'd0, ea_p});
    a_en = 0; a_we = 0; a_sr = 0;
  endtask

  // port B active on falling edge, controls active-low
  task automatic op_b(input bit en, input bit we, input bit sr, input logic [10:0] ad,
                      input logic [7:0] d, input logic p, input string tag);
    @(posedge clk_b);
    b_en_n = ~en; b_we_n = ~we; b_sr_n = ~sr; b_addr = ad; b_wdata = d; b_wpar = p;
    @(negedge clk_b); #1;
    if (en) begin
      if (we) begin
        ref_d[int'(ad)*8 +: 8] = d;
        ref_p[int'(ad)]        = p;
      end
      if (sr) begin eb_d = B_SRD[7:0]; eb_p = B_SRP[0]; end
      else if (we) begin eb_d = d; eb_p = p; end
      else begin eb_d = ref_d[int'(ad)*8 +: 8]; eb_p = ref_p[int'(ad)]; end
    end
    chk({tag, " B data"}, {24'd0, b_rdata}, {24'd0, eb_d});
    chk({tag, " B parity"}, {31'd0, b_rpar}, {31'd0, eb_p});
    b_en_n = 1; b_we_n = 1; b_sr_n = 1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'd4242);
    ref_d = '0;
    ref_p = '0;
    #(CLK_PERIOD * 3);
    // R9: read registers clear under reset
    chk("R9 reset", a_rdata, 32'd0);
    chk("R9 reset", {28'd0, a_rpar}, 32'd0);
    chk("R9 reset", {24'd0, b_rdata}, 32'd0);
    chk("R9 reset", {31'd0, b_rpar}, 32'd0);
    rst_ni = 1'b1;
    #(CLK_PERIOD * 2);

    // R6, R2: fill every 36-bit word through port A
    for (int i = 0; i < 512; i++) op_a(1, 1, 0, 9'(i), $urandom, 4'($urandom), "R6 R2 fill");

    // R3, R4, R10, R1: 9-bit reads of bytes inside 36-bit words
    op_b(1, 0, 0, 11'd5, 8'h00, 1'b0, "R3 R4 R10 R1 byte1 of word1");
    op_b(1, 0, 0, 11'd2047, 8'h00, 1'b0, "R2 R3 top address");
    op_b(1, 1, 0, 11'd6, 8'h5A, 1'b1, "R6 R1 B write");
    op_a(1, 0, 0, 9'd1, 32'd0, 4'd0, "R4 R10 merged word1");
    chk("R4 merged parity bit2", {31'd0, a_rpar[2]}, 32'd1);
    chk("R3 merged byte2", {24'd0, a_rdata[23:16]}, 32'h5A);
    op_a(1, 0, 0, 9'd511, 32'd0, 4'd0, "R2 top word");

    // R7: disabled write has no effect
    op_a(1, 0, 0, 9'd3, 32'd0, 4'd0, "R7 prime");
    op_a(0, 1, 0, 9'd3, 32'hDEAD_BEEF, 4'hF, "R7 disabled write held");
    op_a(1, 0, 0, 9'd3, 32'd0, 4'd0, "R7 memory unchanged");
    op_b(0, 1, 1, 11'd12, 8'hFF, 1'b1, "R7 B disabled held");
    op_b(1, 0, 0, 11'd12, 8'h00, 1'b0, "R7 B memory unchanged");

    // R8: set/reset over write-first, memory still written
    op_a(1, 1, 1, 9'd7, 32'h1234_5678, 4'h9, "R8 A sr with write");
    op_a(1, 0, 0, 9'd7, 32'd0, 4'd0, "R8 A write stored");
    op_b(1, 0, 1, 11'd40, 8'h00, 1'b0, "R8 B sr read");
    op_b(1, 0, 0, 11'd40, 8'h00, 1'b0, "R8 B memory intact");

    // R10 random mixed traffic, one port at a time
    for (int i = 0; i < 1200; i++) begin
      bit en, we, sr;
      en = ($urandom % 8) != 0;
      we = ($urandom % 2) != 0;
      sr = ($urandom % 16) == 0;
      if ($urandom % 2) op_a(en, we, sr, 9'($urandom), $urandom, 4'($urandom), "R10 rand");
      else op_b(en, we, sr, 11'($urandom), 8'($urandom), 1'($urandom), "R10 rand");
    end

    // R9: asynchronous clear mid-run, memory kept
    @(negedge clk_a);
    rst_ni = 1'b0;
    #1;
    chk("R9 async clear A", a_rdata, 32'd0);
    chk("R9 async clear B", {24'd0, b_rdata}, 32'd0);
    ea_d = '0; ea_p = '0; eb_d = '0; eb_p = 1'b0;
    #(CLK_PERIOD * 2);
    rst_ni = 1'b1;
    #(CLK_PERIOD * 2);
    op_a(1, 0, 0, 9'd7, 32'd0, 4'd0, "R9 memory kept");
    op_b(1, 0, 0, 11'd25, 8'd0, 1'b0, "R9 memory kept");

    // R5, R3, R10: narrow instance, 4-bit A and 1-bit B
    @(negedge clk_a);
    na_en = 1; na_we = 1; na_addr = 12'd3; na_wdata = 4'hA; na_wpar = 1;
    @(posedge clk_a); #1;
    chk("R6 narrow write-first", {28'd0, na_rdata}, 32'hA);
    chk("R5 narrow A parity zero", {31'd0, na_rpar}, 32'd0);
    na_en = 0; na_we = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_b);
      nb_en = 1; nb_we = 0; nb_addr = 14'(12 + k); nb_wpar = 1;
      @(posedge clk_b); #1;
      chk("R3 narrow bit read", {31'd0, nb_rdata}, {31'd0, 1'((4'hA >> k) & 4'h1)});
      chk("R5 narrow B parity zero", {31'd0, nb_rpar}, 32'd0);
      nb_en = 0;
    end
    @(negedge clk_b);
    nb_en = 1; nb_we = 1; nb_addr = 14'd12; nb_wdata = 1'b1; nb_wpar = 1;
    @(posedge clk_b); #1;
    chk("R5 narrow B write parity zero", {31'd0, nb_rpar}, 32'd0);
    nb_en = 0; nb_we = 0;
    @(negedge clk_b);
    nb_en = 1; nb_addr = 14'd16383;
    @(posedge clk_b); #1;
    nb_en = 0;
    @(negedge clk_a);
    na_en = 1; na_addr = 12'd3;
    @(posedge clk_a); #1;
    chk("R10 narrow merged nibble", {28'd0, na_rdata}, 32'hB);
    chk("R5 narrow read parity zero", {31'd0, na_rpar}, 32'd0);
    na_en = 0;
    #(CLK_PERIOD * 2);
    finish_run();
  end
endmodule